// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller with Fast/Normal Steering

This block gathers up to 64 level-sensitive, active-high interrupt requests. It splits them into a lower bank of 32 sources and an optional upper bank of 32. Each bank has five word registers on a simple 32-bit read/write bus:

- a raw pending view of the synchronised inputs;
- an enable mask;
- a per-source steering word that chooses between the normal (IRQ) line and the fast (FIQ) line;
- two read-only words that show the pending, enabled sources on each line.

The block drives one registered IRQ line and one registered FIQ line to the processor.

Software enables a source and chooses its line. Software then services a request by reading the status word of the line that fired. A request is cleared at the source, because pending follows the input level. When the parameter `TWO_BANKS` is 0, only the lower bank exists and every upper-bank location reads as zero.

The bus address port `reg_addr` carries a word index, which is the byte offset divided by four. Bit 3 of the index selects the bank, and bits 2:0 select the register within the bank. Reads are combinational. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Each source passes through two flip-flops before it becomes visible. A raw word bit reads 1 two rising edges after its input rises. It reads 0 again two edges after the input falls, with no latching in between.
- R2: The lower bank uses byte offsets 0x00 (raw, read-only), 0x04 (enable), 0x08 (steering), 0x0C (IRQ status) and 0x10 (FIQ status). Enable and steering read back the last value written to them.
- R3: The upper bank uses the same five registers at byte offsets 0x20, 0x24, 0x28, 0x2C and 0x30. Source n (32 to 63) uses bit n-32 of these registers.
- R4: A steering bit of 0 sends the source to IRQ, and a steering bit of 1 sends it to FIQ. A source never shows on both lines at once.
- R5: A source whose enable bit is 0 appears in neither status word and cannot raise either output line.
- R6: The IRQ status word equals raw AND enable AND NOT steering. The FIQ status word equals raw AND enable AND steering. Both are computed per bank.
- R7: `irq_o` is high one edge after any bit of either IRQ status word is set. `fiq_o` behaves the same way for the FIQ status words.
- R8: After reset, all enable and steering bits are 0 and both output lines are low.
- R9: Writes to the raw word and to the two status words of a bank change no register.
- R10: With `TWO_BANKS` = 0, byte offsets 0x20 to 0x30 read zero, and writes to them have no effect.
- R11: Unmapped offsets, such as 0x14 to 0x1C and anything at or above 0x40, read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 32 or 64 | Level interrupt requests, active high |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_o | output | 1 | Registered normal interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
The vector table pairs sources with enable and steering words in both banks. It includes sources steered to opposite lines in the two banks at once, which catches a design that ORs the wrong status words or swaps the meaning of the steering bit.

Directed tests cover several further cases:
- Exact edge counts of input-to-raw and raw-to-line latency, which expose a missing or extra synchronizer stage.
- Release of a request when the input drops, which catches a latched pending bit.
- Writes aimed at read-only and unmapped words, which would corrupt enable or steering if decoded loosely.
- Upper-bank bit mapping with source 33, which exposes an off-by-one bank split.

A second instance with one bank checks that the upper-bank locations stay at zero.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int BANK_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int SYNC_DEP = 2;

  typedef enum logic [2:0] {
    IDX_RAW = 3'd0,
    IDX_EN  = 3'd1,
    IDX_SEL = 3'd2,
    IDX_IRQ = 3'd3,
    IDX_FIQ = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/icu_bank.sv
module icu_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic         en_we,
  input  logic         sel_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] irq_stat,
  output logic [W-1:0] fiq_stat
);
  logic [W-1:0] en_d;
  logic [W-1:0] sel_d;
  logic [W-1:0] live;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (en_we)  en_d  = wdata;
    if (sel_we) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    live     = raw & en_q;
    irq_stat = live & ~sel_q;
    fiq_stat = live & sel_q;
  end
endmodule

// File: rtl/icu_rdmux.sv
module icu_rdmux
  import icu_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NBANK*BANK_W-1:0] raw_w,
  input  logic [NBANK*BANK_W-1:0] en_w,
  input  logic [NBANK*BANK_W-1:0] sel_w,
  input  logic [NBANK*BANK_W-1:0] irq_w,
  input  logic [NBANK*BANK_W-1:0] fiq_w,
  output logic [BANK_W-1:0]       rdata
);
  logic in_window;

  always_comb begin
    in_window = (addr[ADDR_W-1:4] == '0);
    rdata     = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (in_window && (addr[3] == b[0])) begin
        case (reg_idx_e'(addr[2:0]))
          IDX_RAW: rdata = raw_w[b*BANK_W +: BANK_W];
          IDX_EN:  rdata = en_w[b*BANK_W +: BANK_W];
          IDX_SEL: rdata = sel_w[b*BANK_W +: BANK_W];
          IDX_IRQ: rdata = irq_w[b*BANK_W +: BANK_W];
          IDX_FIQ: rdata = fiq_w[b*BANK_W +: BANK_W];
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import icu_pkg::*;
#(
  parameter bit TWO_BANKS = 1'b1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [BANK_W*(TWO_BANKS ? 2 : 1)-1:0]       src_in,
  input  logic                                        reg_wr,
  input  logic [ADDR_W-1:0]                           reg_addr,
  input  logic [BANK_W-1:0]                           reg_wdata,
  output logic [BANK_W-1:0]                           reg_rdata,
  output logic                                        irq_o,
  output logic                                        fiq_o
);
  localparam int NBANK = TWO_BANKS ? 2 : 1;
  localparam int NSRC  = NBANK * BANK_W;

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [NSRC-1:0] raw_flat;
  logic [NSRC-1:0] en_flat;
  logic [NSRC-1:0] sel_flat;
  logic [NSRC-1:0] irq_flat;
  logic [NSRC-1:0] fiq_flat;
  logic            irq_d;
  logic            fiq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  icu_sync #(.W(NSRC), .STAGES(SYNC_DEP)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (src_in),
    .q     (raw_flat)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    logic en_we;
    logic sel_we;

    always_comb begin
      hit    = reg_wr && (reg_addr[ADDR_W-1:4] == '0) && (reg_addr[3] == b[0]);
      en_we  = hit && (reg_addr[2:0] == IDX_EN);
      sel_we = hit && (reg_addr[2:0] == IDX_SEL);
    end

    icu_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .raw      (raw_flat[b*BANK_W +: BANK_W]),
      .en_we    (en_we),
      .sel_we   (sel_we),
      .wdata    (reg_wdata),
      .en_q     (en_flat[b*BANK_W +: BANK_W]),
      .sel_q    (sel_flat[b*BANK_W +: BANK_W]),
      .irq_stat (irq_flat[b*BANK_W +: BANK_W]),
      .fiq_stat (fiq_flat[b*BANK_W +: BANK_W])
    );
  end

  icu_rdmux #(.NBANK(NBANK)) u_rdmux (
    .addr  (reg_addr),
    .raw_w (raw_flat),
    .en_w  (en_flat),
    .sel_w (sel_flat),
    .irq_w (irq_flat),
    .fiq_w (fiq_flat),
    .rdata (reg_rdata)
  );

  always_comb begin
    irq_d = |irq_flat;
    fiq_d = |fiq_flat;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= irq_d;
      fiq_o <= fiq_d;
    end
  end
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int NBANK = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NBANK*32-1:0] src_in,
  input logic              wr_en,
  input logic [5:0]        addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NBANK*32-1:0] en_flat,
  input logic [NBANK*32-1:0] sel_flat,
  input logic [NBANK*32-1:0] irq_flat,
  input logic [NBANK*32-1:0] fiq_flat
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_LINES_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flat & fiq_flat) == '0); // R4

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flat | fiq_flat) & ~en_flat) == '0); // R5

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    age != 2'd0 |-> irq_o == (|$past(irq_flat))); // R7

  AST_FIQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    age != 2'd0 |-> fiq_o == (|$past(fiq_flat))); // R7

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 6'd1 |=> en_flat[31:0] == $past(wdata)); // R2

  AST_EN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 6'd1 |-> rdata == en_flat[31:0]); // R2

  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == 6'd0 || addr == 6'd3 || addr == 6'd4) |=>
      $stable(en_flat) && $stable(sel_flat)); // R9

  AST_RAW_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> ((irq_flat | fiq_flat) & ~$past(src_in, 2)) == '0); // R1

  if (NBANK == 1) begin : g_one
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      addr[5:3] == 3'b001 |-> rdata == '0); // R10
  end
endmodule

bind irq_fiq_ctrl icu_chk #(.NBANK(NBANK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .src_in   (src_in),
  .wr_en    (reg_wr),
  .addr     (reg_addr),
  .wdata    (reg_wdata),
  .rdata    (reg_rdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .en_flat  (en_flat),
  .sel_flat (sel_flat),
  .irq_flat (irq_flat),
  .fiq_flat (fiq_flat)
);

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/100ps
module irq_fiq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [31:0] src32 = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata32;
  logic        irq, fiq, irq32, fiq32;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  irq_fiq_ctrl #(.TWO_BANKS(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .fiq_o(fiq));

  irq_fiq_ctrl #(.TWO_BANKS(1'b0)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .src_in(src32), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata32), .irq_o(irq32), .fiq_o(fiq32));

  // fields: src[193:130] en_lo en_hi sel_lo sel_hi exp_irq exp_fiq
  localparam int NV = 8;
  localparam logic [193:0] VEC [NV] = '{
    {64'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b0},
    {64'h1, 32'h1, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0},
    {64'h0000_0100_0000_0000, 32'h0, 32'h100, 32'h0, 32'h100, 1'b0, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0},
    {64'h8000_0000_0000_0001, 32'h1, 32'h8000_0000, 32'h0, 32'h8000_0000, 1'b1, 1'b1},
    {64'h0000_0000_0000_00F0, 32'h0F, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0},
    {64'hA5A5_A5A5_A5A5_A5A5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1},
    {64'h0000_0002_0000_0000, 32'h0, 32'h2, 32'h0, 32'h0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e_irq, e_fiq;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R8: reset state
    rd_reg(6'd1, d);  check("R8 en_lo", d, 0);
    rd_reg(6'd2, d);  check("R8 sel_lo", d, 0);
    rd_reg(6'd9, d);  check("R8 en_hi", d, 0);
    rd_reg(6'd10, d); check("R8 sel_hi", d, 0);
    check("R8 lines", {irq, fiq}, 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [193:0] t;
      t = VEC[v];
      wr_reg(6'd1, t[129:98]);
      wr_reg(6'd9, t[97:66]);
      wr_reg(6'd2, t[65:34]);
      wr_reg(6'd10, t[33:2]);
      src = t[193:130];
      settle();
      e_irq = src & {t[97:66], t[129:98]} & ~{t[33:2], t[65:34]};
      e_fiq = src & {t[97:66], t[129:98]} & {t[33:2], t[65:34]};
      rd_reg(6'd0, d);  check("R2 raw_lo", d, src[31:0]);
      rd_reg(6'd8, d);  check("R3 raw_hi", d, src[63:32]);
      rd_reg(6'd1, d);  check("R2 en_lo", d, t[129:98]);
      rd_reg(6'd10, d); check("R3 sel_hi", d, t[33:2]);
      rd_reg(6'd3, d);  check("R6 irq_lo", d, e_irq[31:0]);
      rd_reg(6'd4, d);  check("R6 fiq_lo", d, e_fiq[31:0]);
      rd_reg(6'd11, d); check("R3 irq_hi", d, e_irq[63:32]);
      rd_reg(6'd12, d); check("R4 fiq_hi", d, e_fiq[63:32]);
      check("R7 irq line", irq, t[1]);
      check("R5 fiq line", fiq, t[0]);
    end

    // R1 / R7 latency and level release
    wr_reg(6'd1, 32'h8); wr_reg(6'd9, 0); wr_reg(6'd2, 0); wr_reg(6'd10, 0);
    src = '0;
    settle();
    addr = 6'd0;
    @(negedge clk); src = 64'h8;
    @(posedge clk); @(posedge clk); #1;
    check("R1 raw after two edges", rdata, 32'h8);
    check("R7 irq not yet", irq, 1'b0);
    @(posedge clk); #1;
    check("R7 irq after third edge", irq, 1'b1);
    @(negedge clk); src = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 raw released", rdata, 0);
    @(posedge clk); #1;
    check("R1 irq released", irq, 1'b0);

    // R9 read-only words
    wr_reg(6'd1, 32'h0000_00F0); wr_reg(6'd2, 32'h0000_0030);
    src = 64'h50;
    settle();
    wr_reg(6'd0, 32'hFFFF_FFFF);
    wr_reg(6'd3, 32'hFFFF_FFFF);
    wr_reg(6'd4, 32'h0);
    wr_reg(6'd8, 32'hFFFF_FFFF);
    rd_reg(6'd1, d); check("R9 en kept", d, 32'hF0);
    rd_reg(6'd2, d); check("R9 sel kept", d, 32'h30);
    rd_reg(6'd0, d); check("R9 raw kept", d, 32'h50);
    rd_reg(6'd3, d); check("R9 irq word", d, 32'h40);
    rd_reg(6'd4, d); check("R9 fiq word", d, 32'h10);

    // R11 unmapped
    wr_reg(6'd5, 32'hFFFF_FFFF);
    wr_reg(6'd16, 32'hFFFF_FFFF);
    rd_reg(6'd5, d);  check("R11 read 0x14", d, 0);
    rd_reg(6'd7, d);  check("R11 read 0x1C", d, 0);
    rd_reg(6'd16, d); check("R11 read 0x40", d, 0);
    rd_reg(6'd1, d);  check("R11 en untouched", d, 32'hF0);
    rd_reg(6'd2, d);  check("R11 sel untouched", d, 32'h30);

    // R10 single-bank instance
    src = '0;
    wr_reg(6'd1, 32'h4); wr_reg(6'd2, 32'h4);
    wr_reg(6'd9, 32'hFFFF_FFFF); wr_reg(6'd10, 32'hFFFF_FFFF);
    src32 = 32'h4;
    settle();
    @(negedge clk); addr = 6'd9;  #1 check("R10 upper en reads 0", rdata32, 0);
    @(negedge clk); addr = 6'd8;  #1 check("R10 upper raw reads 0", rdata32, 0);
    @(negedge clk); addr = 6'd10; #1 check("R10 upper sel reads 0", rdata32, 0);
    @(negedge clk); addr = 6'd4;  #1 check("R10 lower fiq word", rdata32, 32'h4);
    check("R10 fiq line", fiq32, 1'b1);
    check("R10 irq line", irq32, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule